// File: doc/BRIEF.md
# Register and Memory Move Sequencer

This block executes the data movement class of instructions for a 64-bit register machine. Each instruction names an operation, two 6-bit register indices (a destination-side index A and a source-side index B) and a 32-bit immediate. The block moves values between an external 64-entry register file and a byte-addressed memory. It supports register loads from memory, register stores to memory, register-to-register copies, immediate moves and direct memory-to-memory word copies.

The register file port has a synchronous read: a read enable presented in one cycle returns data in the next cycle. The write port takes one strobe per write. The memory port holds a request until the memory answers with ready. The register space has a fixed map: indices 0..3 are the instruction pointer, stack pointer, frame pointer and flags. Indices 4..12 are unimplemented. Index 13 is a status register and 14..63 are general registers. The sequencer enforces the rule for the unimplemented slots itself.

Top module: `dmov_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, `mem_req`, `rf_we`, `rf_rd_en`, `done` and `busy` are low.
- R2: Operation code 2 (immediate move) writes register A with the 32-bit immediate zero-extended to 64 bits. `rf_we` and `done` rise in the cycle after `start` is accepted.
- R3: Operation code 4 (register copy) writes register A with the value of register B.
- R4: Operation code 0 (load) reads a 64-bit word from the memory address held in register B and writes it to register A. The register write happens only after the memory read completes.
- R5: Operation code 1 (store) writes the value of register A to the memory address held in register B. The data bus is little-endian: bits 8k+7..8k travel to byte address `mem_addr`+k.
- R6: Operation code 3 (memory copy) performs exactly two memory accesses and writes no register. First it reads the word at the address in register B. Then, in a separate request, it writes that word to the address in register A.
- R7: Once `mem_req` is raised, it stays high with `mem_we`, `mem_addr` and `mem_wdata` unchanged until a cycle in which `mem_ready` is high. The request then drops in the next cycle.
- R8: A write aimed at an index in 4..12 produces no `rf_we`. The instruction still completes with `done`.
- R9: Reading an index in 4..12 yields zero, whatever the register file returns.
- R10: `done` is high for exactly one cycle per accepted instruction, and `busy` is low whenever `done` is high. A `start` that arrives while `busy` is high is ignored.
- R11: Operation codes 5..7 complete with a single `done` and cause no register or memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Accept an instruction when not busy |
| op | input | 3 | Operation code |
| idx_a | input | 6 | Register index A (destination of register writes, data/destination for stores and copies) |
| idx_b | input | 6 | Register index B (source value or source address) |
| imm | input | 32 | Immediate for the immediate move |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| rf_rd_en | output | 1 | Register file read enable |
| rf_rd_idx | output | 6 | Register file read index |
| rf_rd_data | input | 64 | Read data, valid the cycle after `rf_rd_en` |
| rf_we | output | 1 | Register file write strobe |
| rf_wr_idx | output | 6 | Register file write index |
| rf_wr_data | output | 64 | Register file write data |
| mem_req | output | 1 | Memory request, held until ready |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 64 | Byte address of the lowest byte of the word |
| mem_wdata | output | 64 | Write data, little-endian |
| mem_ready | input | 1 | Memory completes the pending request |
| mem_rdata | input | 64 | Read data, valid while `mem_ready` is high |

## Verification
The assertions assume several things about the environment. Reset is applied at the first clock edge. `mem_ready` is raised only while a request is pending and stays high for a single cycle. The register file honours the one-cycle read latency. The stimulus models the memory with a ready generator that waits a programmable number of cycles after seeing `mem_req` and then pulses ready once. The register file model returns data one edge after the read enable. Instructions are issued only when `busy` is low, except in the one scenario that deliberately presents `start` mid-instruction.

// File: rtl/dmov_pkg.sv
package dmov_pkg;

  // Register space map: indices UNUSED_LO .. UNUSED_LO+UNUSED_CNT-1 are unimplemented
  localparam int UNUSED_LO  = 4;
  localparam int UNUSED_CNT = 9;

  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_MOVI  = 3'd2,
    OP_MCOPY = 3'd3,
    OP_RCOPY = 3'd4
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_RB_WAIT,
    S_RB_CAP,
    S_RA_WAIT,
    S_RA_CAP,
    S_MEM_RD,
    S_CP_HOLD,
    S_MEM_WR
  } seq_state_e;

endpackage

// File: rtl/dmov_regmap.sv
module dmov_regmap #(
  parameter int IDX_W  = 6,
  parameter int DATA_W = 64
) (
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [DATA_W-1:0] rd_raw,
  input  logic [IDX_W-1:0]  wr_idx,
  output logic [DATA_W-1:0] rd_val,
  output logic              wr_ok
);
  import dmov_pkg::*;

  localparam int NREG = 1 << IDX_W;

  logic [NREG-1:0] hole_map;

  // One flag per register slot marking the unimplemented range
  for (genvar g = 0; g < NREG; g++) begin : g_map
    if (g >= UNUSED_LO && g < UNUSED_LO + UNUSED_CNT) begin : g_hole
      assign hole_map[g] = 1'b1;
    end else begin : g_real
      assign hole_map[g] = 1'b0;
    end
  end

  always_comb begin
    rd_val = hole_map[rd_idx] ? '0 : rd_raw;
    wr_ok  = ~hole_map[wr_idx];
  end

endmodule

// File: rtl/dmov_memport.sv
module dmov_memport #(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iss,
  input  logic              iss_we,
  input  logic [ADDR_W-1:0] iss_addr,
  input  logic [DATA_W-1:0] iss_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  output logic              xfer_ok
);

  // Request fields are frozen from issue until the ready handshake
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else if (iss) begin
      mem_req   <= 1'b1;
      mem_we    <= iss_we;
      mem_addr  <= iss_addr;
      mem_wdata <= iss_wdata;
    end else if (mem_req && mem_ready) begin
      mem_req   <= 1'b0;
    end
  end

  assign xfer_ok = mem_req & mem_ready;

endmodule

// File: rtl/dmov_ctrl.sv
module dmov_ctrl #(
  parameter int IDX_W  = 6,
  parameter int DATA_W = 64,
  parameter int ADDR_W = 64,
  parameter int IMM_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        op,
  input  logic [IDX_W-1:0]  idx_a,
  input  logic [IDX_W-1:0]  idx_b,
  input  logic [IMM_W-1:0]  imm,
  input  logic [DATA_W-1:0] rd_val,
  input  logic              wr_ok,
  output logic [IDX_W-1:0]  chk_idx,
  output logic              busy,
  output logic              done,
  output logic              rf_rd_en,
  output logic [IDX_W-1:0]  rf_rd_idx,
  output logic              rf_we,
  output logic [IDX_W-1:0]  rf_wr_idx,
  output logic [DATA_W-1:0] rf_wr_data,
  output logic              iss,
  output logic              iss_we,
  output logic [ADDR_W-1:0] iss_addr,
  output logic [DATA_W-1:0] iss_wdata,
  input  logic              xfer_ok,
  input  logic [DATA_W-1:0] xfer_rdata
);
  import dmov_pkg::*;

  localparam int ZEXT_W = DATA_W - IMM_W;

  seq_state_e        state;
  op_e               op_q;
  logic [IDX_W-1:0]  ia_q;
  logic [DATA_W-1:0] vb_q;
  logic [DATA_W-1:0] va_q;
  logic [DATA_W-1:0] cp_buf;

  always_comb begin
    busy    = (state != S_IDLE);
    chk_idx = (state == S_IDLE) ? idx_a : ia_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      op_q       <= OP_LOAD;
      ia_q       <= '0;
      vb_q       <= '0;
      va_q       <= '0;
      cp_buf     <= '0;
      done       <= 1'b0;
      rf_rd_en   <= 1'b0;
      rf_rd_idx  <= '0;
      rf_we      <= 1'b0;
      rf_wr_idx  <= '0;
      rf_wr_data <= '0;
      iss        <= 1'b0;
      iss_we     <= 1'b0;
      iss_addr   <= '0;
      iss_wdata  <= '0;
    end else begin
      rf_rd_en <= 1'b0;
      rf_we    <= 1'b0;
      done     <= 1'b0;
      iss      <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            op_q <= op_e'(op);
            ia_q <= idx_a;
            case (op_e'(op))
              OP_MOVI: begin
                rf_we      <= wr_ok;
                rf_wr_idx  <= idx_a;
                rf_wr_data <= {{ZEXT_W{1'b0}}, imm};
                done       <= 1'b1;
              end
              OP_LOAD, OP_STORE, OP_MCOPY, OP_RCOPY: begin
                rf_rd_en  <= 1'b1;
                rf_rd_idx <= idx_b;
                state     <= S_RB_WAIT;
              end
              default: done <= 1'b1;
            endcase
          end
        end
        S_RB_WAIT: state <= S_RB_CAP;
        S_RB_CAP: begin
          vb_q <= rd_val;
          case (op_q)
            OP_RCOPY: begin
              rf_we      <= wr_ok;
              rf_wr_idx  <= ia_q;
              rf_wr_data <= rd_val;
              done       <= 1'b1;
              state      <= S_IDLE;
            end
            OP_LOAD: begin
              iss      <= 1'b1;
              iss_we   <= 1'b0;
              iss_addr <= ADDR_W'(rd_val);
              state    <= S_MEM_RD;
            end
            default: begin
              rf_rd_en  <= 1'b1;
              rf_rd_idx <= ia_q;
              state     <= S_RA_WAIT;
            end
          endcase
        end
        S_RA_WAIT: state <= S_RA_CAP;
        S_RA_CAP: begin
          va_q     <= rd_val;
          iss      <= 1'b1;
          iss_addr <= ADDR_W'(vb_q);
          if (op_q == OP_STORE) begin
            iss_we    <= 1'b1;
            iss_wdata <= rd_val;
            state     <= S_MEM_WR;
          end else begin
            iss_we <= 1'b0;
            state  <= S_MEM_RD;
          end
        end
        S_MEM_RD: begin
          if (xfer_ok) begin
            if (op_q == OP_LOAD) begin
              rf_we      <= wr_ok;
              rf_wr_idx  <= ia_q;
              rf_wr_data <= xfer_rdata;
              done       <= 1'b1;
              state      <= S_IDLE;
            end else begin
              cp_buf <= xfer_rdata;
              state  <= S_CP_HOLD;
            end
          end
        end
        S_CP_HOLD: begin
          iss       <= 1'b1;
          iss_we    <= 1'b1;
          iss_addr  <= ADDR_W'(va_q);
          iss_wdata <= cp_buf;
          state     <= S_MEM_WR;
        end
        S_MEM_WR: begin
          if (xfer_ok) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dmov_seq.sv
module dmov_seq #(
  parameter int IDX_W  = 6,
  parameter int DATA_W = 64,
  parameter int ADDR_W = 64,
  parameter int IMM_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        op,
  input  logic [IDX_W-1:0]  idx_a,
  input  logic [IDX_W-1:0]  idx_b,
  input  logic [IMM_W-1:0]  imm,
  output logic              busy,
  output logic              done,
  output logic              rf_rd_en,
  output logic [IDX_W-1:0]  rf_rd_idx,
  input  logic [DATA_W-1:0] rf_rd_data,
  output logic              rf_we,
  output logic [IDX_W-1:0]  rf_wr_idx,
  output logic [DATA_W-1:0] rf_wr_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata
);

  logic [DATA_W-1:0] rd_val;
  logic              wr_ok;
  logic [IDX_W-1:0]  chk_idx;
  logic              iss;
  logic              iss_we;
  logic [ADDR_W-1:0] iss_addr;
  logic [DATA_W-1:0] iss_wdata;
  logic              xfer_ok;

  dmov_regmap #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_map (
    .rd_idx (rf_rd_idx),
    .rd_raw (rf_rd_data),
    .wr_idx (chk_idx),
    .rd_val (rd_val),
    .wr_ok  (wr_ok)
  );

  dmov_ctrl #(.IDX_W(IDX_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .op         (op),
    .idx_a      (idx_a),
    .idx_b      (idx_b),
    .imm        (imm),
    .rd_val     (rd_val),
    .wr_ok      (wr_ok),
    .chk_idx    (chk_idx),
    .busy       (busy),
    .done       (done),
    .rf_rd_en   (rf_rd_en),
    .rf_rd_idx  (rf_rd_idx),
    .rf_we      (rf_we),
    .rf_wr_idx  (rf_wr_idx),
    .rf_wr_data (rf_wr_data),
    .iss        (iss),
    .iss_we     (iss_we),
    .iss_addr   (iss_addr),
    .iss_wdata  (iss_wdata),
    .xfer_ok    (xfer_ok),
    .xfer_rdata (mem_rdata)
  );

  dmov_memport #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk       (clk),
    .rst       (rst),
    .iss       (iss),
    .iss_we    (iss_we),
    .iss_addr  (iss_addr),
    .iss_wdata (iss_wdata),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ready (mem_ready),
    .xfer_ok   (xfer_ok)
  );

endmodule

// File: rtl/dmov_seq_chk.sv
module dmov_seq_chk #(
  parameter int IDX_W  = 6,
  parameter int DATA_W = 64,
  parameter int ADDR_W = 64,
  parameter int IMM_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [2:0]        op,
  input logic [IDX_W-1:0]  idx_a,
  input logic [IMM_W-1:0]  imm,
  input logic              busy,
  input logic              done,
  input logic              rf_rd_en,
  input logic              rf_we,
  input logic [IDX_W-1:0]  rf_wr_idx,
  input logic [DATA_W-1:0] rf_wr_data,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ready
);
  import dmov_pkg::*;

  function automatic logic is_hole(input logic [IDX_W-1:0] i);
    return (int'(i) >= UNUSED_LO) && (int'(i) < UNUSED_LO + UNUSED_CNT);
  endfunction

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!mem_req && !rf_we && !rf_rd_en && !done && !busy));

  assert_movi_zext_R2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && op == 3'd2 && !is_hole(idx_a)) |=>
      (rf_we && done && rf_wr_idx == $past(idx_a) &&
       rf_wr_data[IMM_W-1:0] == $past(imm) && rf_wr_data[DATA_W-1:IMM_W] == '0));

  // R4/R6: register writes never overlap an open memory request
  assert_no_rf_during_mem_R4: assert property (@(posedge clk) disable iff (rst)
    !(mem_req && rf_we));

  assert_req_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=>
      (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

  assert_req_drop_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ready) |=> !mem_req);

  assert_no_hole_write_R8: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> !is_hole(rf_wr_idx));

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

endmodule

bind dmov_seq dmov_seq_chk #(.IDX_W(IDX_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .op         (op),
  .idx_a      (idx_a),
  .imm        (imm),
  .busy       (busy),
  .done       (done),
  .rf_rd_en   (rf_rd_en),
  .rf_we      (rf_we),
  .rf_wr_idx  (rf_wr_idx),
  .rf_wr_data (rf_wr_data),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .mem_ready  (mem_ready)
);

// File: tb/dmov_seq_bench.sv
module dmov_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic [5:0]  idx_a = '0;
  logic [5:0]  idx_b = '0;
  logic [31:0] imm = '0;
  logic        busy, done, rf_rd_en, rf_we, mem_req, mem_we;
  logic [5:0]  rf_rd_idx, rf_wr_idx;
  logic [63:0] rf_rd_data = '0;
  logic [63:0] rf_wr_data, mem_addr, mem_wdata;
  logic        mem_ready = 1'b0;
  logic [63:0] mem_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmov_seq u_dmov_seq (
    .clk(clk), .rst(rst), .start(start), .op(op), .idx_a(idx_a), .idx_b(idx_b), .imm(imm),
    .busy(busy), .done(done), .rf_rd_en(rf_rd_en), .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
    .rf_we(rf_we), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  // Register file and memory models; bench writes go through poke strobes
  logic [63:0] regs [64];
  logic [7:0]  mem  [256];
  logic        poke_r = 0, poke_m = 0;
  logic [5:0]  poke_ri = '0;
  logic [7:0]  poke_ma = '0;
  logic [63:0] poke_v = '0;
  int lat = 0;
  int wcnt = 0;
  int rf_wr_cnt = 0;
  int acc_cnt = 0;
  logic [1:0] we_hist = '0;
  int done_cnt = 0;
  int hold_viol = 0;
  logic       p_req = 0, p_ready = 0, p_we = 0;
  logic [63:0] p_addr = '0, p_wdata = '0;

  initial begin
    for (int i = 0; i < 64; i++) regs[i] = 64'hF00D_0000_0000_0000 | (64'(i) * 64'h0001_0203_0405);
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
  end

  always @(posedge clk) begin
    if (rf_rd_en) rf_rd_data <= regs[rf_rd_idx];
    if (rf_we) begin regs[rf_wr_idx] <= rf_wr_data; rf_wr_cnt <= rf_wr_cnt + 1; end
    if (poke_r) regs[poke_ri] <= poke_v;
    if (poke_m) for (int k = 0; k < 8; k++) mem[8'(poke_ma + 8'(k))] <= poke_v[8*k +: 8];
    if (mem_req && mem_ready) begin
      acc_cnt <= acc_cnt + 1;
      we_hist <= {we_hist[0], mem_we};
      if (mem_we) for (int k = 0; k < 8; k++) mem[8'(mem_addr[7:0] + 8'(k))] <= mem_wdata[8*k +: 8];
    end
    if (rst) begin mem_ready <= 0; wcnt <= 0; end
    else if (mem_ready) begin mem_ready <= 0; wcnt <= 0; end
    else if (mem_req) begin
      if (wcnt >= lat) mem_ready <= 1; else wcnt <= wcnt + 1;
    end
  end

  always_comb
    for (int k = 0; k < 8; k++) mem_rdata[8*k +: 8] = mem[8'(mem_addr[7:0] + 8'(k))];

  // Monitor at the falling edge: done pulses and request stability
  always @(negedge clk) begin
    if (!rst) begin
      if (done) done_cnt++;
      if (p_req && !p_ready &&
          (!mem_req || mem_we != p_we || mem_addr != p_addr || mem_wdata != p_wdata)) hold_viol++;
    end
    p_req = mem_req; p_ready = mem_ready; p_we = mem_we; p_addr = mem_addr; p_wdata = mem_wdata;
  end

  function automatic logic [63:0] le_word(input logic [7:0] a);
    logic [63:0] w;
    for (int k = 0; k < 8; k++) w[8*k +: 8] = mem[8'(a + 8'(k))];
    return w;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic set_reg(input logic [5:0] i, input logic [63:0] v);
    @(negedge clk); poke_r = 1; poke_ri = i; poke_v = v;
    @(negedge clk); poke_r = 0;
  endtask

  task automatic set_mem(input logic [7:0] a, input logic [63:0] v);
    @(negedge clk); poke_m = 1; poke_ma = a; poke_v = v;
    @(negedge clk); poke_m = 0;
  endtask

  task automatic run(input logic [2:0] o, input logic [5:0] a, input logic [5:0] b, input logic [31:0] im);
    int d0;
    d0 = done_cnt;
    @(negedge clk); start = 1; op = o; idx_a = a; idx_b = b; imm = im;
    @(negedge clk); start = 0;
    for (int t = 0; t < 300 && done_cnt == d0; t++) @(negedge clk);
    if (done_cnt == d0) check("R10", 0, 1, "done never seen");
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1", {59'd0, mem_req, rf_we, rf_rd_en, done, busy}, 64'd0, "outputs after reset");
  endtask

  task automatic t_movi;
    int d0;
    d0 = done_cnt;
    @(negedge clk); start = 1; op = 3'd2; idx_a = 6'd20; idx_b = 0; imm = 32'hDEAD_BEEF;
    @(negedge clk); start = 0;
    check("R2", {62'd0, rf_we, done}, 64'd3, "write and done one cycle after start");
    @(negedge clk);
    check("R2", regs[20], 64'h0000_0000_DEAD_BEEF, "zero-extended immediate");
    check("R10", 64'(done_cnt - d0), 64'd1, "single done for immediate move");
    run(3'd2, 6'd0, 6'd0, 32'h8000_0001);
    check("R2", regs[0], 64'h0000_0000_8000_0001, "immediate into index 0");
  endtask

  task automatic t_rcopy;
    run(3'd4, 6'd21, 6'd13, 0);
    check("R3", regs[21], regs[13], "copy from index 13");
    set_reg(6'd40, 64'h0123_4567_89AB_CDEF);
    run(3'd4, 6'd63, 6'd40, 0);
    check("R3", regs[63], 64'h0123_4567_89AB_CDEF, "copy into index 63");
  endtask

  task automatic t_load;
    logic [63:0] e;
    lat = 0;
    set_reg(6'd30, 64'd16);
    e = le_word(8'd16);
    run(3'd0, 6'd22, 6'd30, 0);
    check("R4", regs[22], e, "load aligned, ready at once");
    lat = 5;
    set_reg(6'd30, 64'd37);
    e = le_word(8'd37);
    run(3'd0, 6'd23, 6'd30, 0);
    check("R4", regs[23], e, "load unaligned, slow ready");
    check("R7", 64'(hold_viol), 64'd0, "request stable while waiting");
  endtask

  task automatic t_store;
    lat = 3;
    set_reg(6'd31, 64'd64);
    set_reg(6'd24, 64'h1122_3344_5566_7788);
    run(3'd1, 6'd24, 6'd31, 0);
    check("R5", {56'd0, mem[64]}, 64'h88, "lowest byte at base address");
    check("R5", {56'd0, mem[71]}, 64'h11, "highest byte at base+7");
    check("R5", le_word(8'd64), 64'h1122_3344_5566_7788, "stored word");
  endtask

  task automatic t_mcopy;
    logic [63:0] e;
    int w0, a0;
    lat = 2;
    set_reg(6'd32, 64'd128);
    set_reg(6'd33, 64'd72);
    set_mem(8'd72, 64'hCAFE_F00D_BAAD_1234);
    e = le_word(8'd72);
    w0 = rf_wr_cnt; a0 = acc_cnt;
    run(3'd3, 6'd32, 6'd33, 0);
    check("R6", le_word(8'd128), 64'hCAFE_F00D_BAAD_1234, "word copied");
    check("R6", le_word(8'd72), e, "source intact");
    check("R6", 64'(acc_cnt - a0), 64'd2, "two memory accesses");
    check("R6", {62'd0, we_hist}, 64'b01, "read then write");
    check("R6", 64'(rf_wr_cnt - w0), 64'd0, "no register write");
  endtask

  task automatic t_holes;
    int w0, d0;
    logic [63:0] old7;
    old7 = regs[7];
    w0 = rf_wr_cnt; d0 = done_cnt;
    run(3'd2, 6'd7, 6'd0, 32'h5555_5555);
    check("R8", 64'(rf_wr_cnt - w0), 64'd0, "immediate to index 7 dropped");
    check("R8", 64'(done_cnt - d0), 64'd1, "done still pulses");
    run(3'd4, 6'd12, 6'd20, 0);
    check("R8", 64'(rf_wr_cnt - w0), 64'd0, "copy to index 12 dropped");
    run(3'd4, 6'd25, 6'd7, 0);
    check("R8", regs[7], old7, "index 7 untouched");
    check("R9", regs[25], 64'd0, "read of index 7 is zero");
    run(3'd4, 6'd26, 6'd4, 0);
    check("R9", regs[26], 64'd0, "read of index 4 is zero");
    lat = 1;
    set_reg(6'd27, 64'hA1A2_A3A4_A5A6_A7A8);
    run(3'd1, 6'd27, 6'd9, 0);
    check("R9", le_word(8'd0), 64'hA1A2_A3A4_A5A6_A7A8, "store via hole address lands at 0");
  endtask

  task automatic t_busy;
    int d0;
    logic [63:0] old20;
    lat = 6;
    old20 = regs[20];
    set_reg(6'd30, 64'd200);
    d0 = done_cnt;
    @(negedge clk); start = 1; op = 3'd0; idx_a = 6'd28; idx_b = 6'd30;
    @(negedge clk); start = 0;
    repeat (3) @(negedge clk);
    check("R10", {63'd0, busy}, 64'd1, "busy mid-load");
    start = 1; op = 3'd2; idx_a = 6'd20; imm = 32'h0BAD_0BAD;
    @(negedge clk); start = 0;
    repeat (40) @(negedge clk);
    check("R10", 64'(done_cnt - d0), 64'd1, "one done, start while busy ignored");
    check("R10", regs[20], old20, "ignored immediate had no effect");
    check("R4", regs[28], le_word(8'd200), "load result under overlap attempt");
  endtask

  task automatic t_undef;
    int w0, a0, d0;
    w0 = rf_wr_cnt; a0 = acc_cnt; d0 = done_cnt;
    run(3'd5, 6'd20, 6'd30, 32'h1);
    run(3'd7, 6'd21, 6'd31, 32'h2);
    check("R11", 64'(done_cnt - d0), 64'd2, "one done each");
    check("R11", 64'(rf_wr_cnt - w0), 64'd0, "no register write");
    check("R11", 64'(acc_cnt - a0), 64'd0, "no memory access");
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset;
    t_movi;
    t_rcopy;
    t_load;
    t_store;
    t_mcopy;
    t_holes;
    t_busy;
    t_undef;
    check("R7", 64'(hold_viol), 64'd0, "request stability over whole run");
    finish_run;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run;
  end

endmodule